// File: doc/BRIEF.md
# PHY Management Register Responder

This block is a single memory-mapped management register that stands in for a serial PHY management link. Software writes a 32-bit command word holding a PHY/register address field and a read opcode bit. A later read of the same offset returns an answer taken from a small built-in table: a fixed link status word, the two halves of a fixed PHY identifier, or an empty answer. Every answer to a read command carries a read-valid flag. When the stored command has no read opcode, the register reads as zero. No serial clock or data line is produced; the answer is formed from the latched command alone.

The block sits behind a simple register-bus slave port with a byte address, write enable, write data, read enable and read data. Only one offset of the window is decoded. Every other offset reads as zero and ignores writes. Read data is registered and holds its value between reads. The reset input is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `mgmt_phy_resp`

## Requirements
- R1: While reset is asserted, and after release until a command is written, the stored command is zero, the read data output is zero, and a read of the command offset returns 0x00000000.
- R2: A write with the byte address equal to 0x010 stores the whole 32-bit write word as the command. The answer depends only on bit 26 (read opcode) and bits 25:16 (address field); the command word's data bits 15:0 and bits 31:27 have no effect on it.
- R3: When bit 26 of the stored command is 0, a read of offset 0x010 returns 0x00000000, whatever the address field holds.
- R4: With bit 26 set and address field 0x021, a read returns 0x0800000C: bit 27 (read valid) set, plus the link-up bit 0x0004 and the autonegotiation-capable bit 0x0008 in bits 15:0.
- R5: With bit 26 set and address field 0x041, a read returns 0x08000141, which is bit 27 plus the upper half of the identifier 0x01410E20.
- R6: With bit 26 set and address field 0x061, a read returns 0x08000E20, which is bit 27 plus the lower half of the identifier.
- R7: With bit 26 set and any other address field value, a read returns 0x08000000. In every answer, bits 31:28 and 26:16 are zero.
- R8: A read of any byte address other than 0x010 returns 0x00000000. A write to any other address leaves the stored command unchanged, as seen through a later read of 0x010.
- R9: Read data appears on the output one clock after the cycle with read enable high, and holds until the next read. A read in the same cycle as a write to 0x010 returns the answer for the command stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| bus_addr | input | 12 | Byte address within the register window |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable, one cycle per read |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench sweeps all 1024 values of the address field, with the opcode set and with it clear. It varies the command's data bits and top bits during the sweep, so a table that decodes too few or too many bits, or that lets the stored data leak into the answer, returns a wrong word for some address. It then reads every word offset of the window except the command register and writes to a spread of unmapped offsets. A decoder that ignores high address bits would alias there, and would either return the answer or overwrite the command. Separate checks cover a read in the same cycle as a write, which must see the old command, and idle cycles after a read, where a design that clears or recomputes the output would change the read data.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int CMD_W     = 32;
  localparam int FIELD_W   = 10;
  localparam int PAYLOAD_W = 16;

  typedef struct packed {
    logic [3:0]           rsvd;
    logic                 valid;
    logic                 rd_op;
    logic [FIELD_W-1:0]   field;
    logic [PAYLOAD_W-1:0] payload;
  } cmd_t;

  localparam logic [31:0] PHY_ID     = 32'h0141_0E20;
  localparam logic [15:0] LINK_UP    = 16'h0004;
  localparam logic [15:0] ANEG_ABLE  = 16'h0008;

  localparam int NUM_ENTRIES = 3;

  function automatic logic [FIELD_W-1:0] entry_key(input int idx);
    case (idx)
      0:       entry_key = 10'h021;
      1:       entry_key = 10'h041;
      default: entry_key = 10'h061;
    endcase
  endfunction

  function automatic logic [PAYLOAD_W-1:0] entry_val(input int idx);
    case (idx)
      0:       entry_val = LINK_UP | ANEG_ABLE;
      1:       entry_val = PHY_ID[31:16];
      default: entry_val = PHY_ID[15:0];
    endcase
  endfunction

endpackage

// File: rtl/mgmt_rst_sync.sv
module mgmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mgmt_cmd_reg.sv
module mgmt_cmd_reg
  import mgmt_phy_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  logic [CMD_W-1:0] load_val,
  output cmd_t       cmd
);

  cmd_t cmd_q;
  cmd_t cmd_d;

  always_comb begin
    cmd_d = cmd_q;
    if (load_en) begin
      cmd_d = cmd_t'(load_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else begin
      cmd_q <= cmd_d;
    end
  end

  assign cmd = cmd_q;

endmodule

// File: rtl/mgmt_resp_table.sv
module mgmt_resp_table
  import mgmt_phy_pkg::*;
(
  input  cmd_t             cmd,
  output logic [CMD_W-1:0] resp
);

  logic [NUM_ENTRIES-1:0] hit;
  logic [PAYLOAD_W-1:0]   hit_val [NUM_ENTRIES];
  logic [PAYLOAD_W-1:0]   merged;
  cmd_t                   ans;

  for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
    assign hit[gi]     = (cmd.field == entry_key(gi));
    assign hit_val[gi] = hit[gi] ? entry_val(gi) : '0;
  end

  always_comb begin
    merged = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      merged = merged | hit_val[i];
    end
  end

  always_comb begin
    ans = '0;
    if (cmd.rd_op) begin
      ans.valid   = 1'b1;
      ans.payload = merged;
    end
  end

  assign resp = ans;

endmodule

// File: rtl/mgmt_phy_resp.sv
module mgmt_phy_resp
  import mgmt_phy_pkg::*;
#(
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h010,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CMD_W-1:0]  bus_wdata,
  input  logic              bus_re,
  output logic [CMD_W-1:0]  bus_rdata
);

  logic             rst_int_n;
  logic             sel;
  logic             cmd_load;
  cmd_t             cmd_q;
  logic [CMD_W-1:0] resp;
  logic [CMD_W-1:0] rdata_q;
  logic [CMD_W-1:0] rdata_d;

  mgmt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign sel      = (bus_addr == CMD_OFFSET);
  assign cmd_load = bus_we & sel;

  mgmt_cmd_reg u_cmd (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (cmd_load),
    .load_val (bus_wdata),
    .cmd      (cmd_q)
  );

  mgmt_resp_table u_tbl (
    .cmd  (cmd_q),
    .resp (resp)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (bus_re) begin
      rdata_d = sel ? resp : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/mgmt_phy_resp_chk.sv
module mgmt_phy_resp_chk
  import mgmt_phy_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] CMD_OFFSET = 12'h010
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [CMD_W-1:0]  bus_wdata,
  input logic              bus_re,
  input logic [CMD_W-1:0]  bus_rdata,
  input logic [CMD_W-1:0]  cmd_word
);

  logic at_cmd;
  assign at_cmd = (bus_addr == CMD_OFFSET);

  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && at_cmd) |=> (cmd_word == $past(bus_wdata))); // R2

  AST_NO_OPC_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_re && at_cmd && !cmd_word[26]) |=> (bus_rdata == '0)); // R3

  AST_VALID_FOLLOWS_OPC: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_re && at_cmd) |=> (bus_rdata[27] == $past(cmd_word[26]))); // R7

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_re |=> (bus_rdata[31:28] == 4'h0 && bus_rdata[26:16] == 11'h0)); // R7

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_re && !at_cmd) |=> (bus_rdata == '0)); // R8

  AST_UNMAPPED_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_we && !at_cmd) |=> $stable(cmd_word)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_re |=> $stable(bus_rdata)); // R9

endmodule

bind mgmt_phy_resp mgmt_phy_resp_chk #(
  .ADDR_W     (ADDR_W),
  .CMD_OFFSET (CMD_OFFSET)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .cmd_word  (cmd_q)
);

// File: tb/mgmt_phy_resp_test.sv
module mgmt_phy_resp_test;

  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFF = 12'h010;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [31:0]       bus_wdata;
  logic              bus_re;
  logic [31:0]       bus_rdata;

  int checks;
  int errors;
  bit done;

  mgmt_phy_resp uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] expect_resp(input logic [31:0] cmd);
    logic [9:0] f;
    f = cmd[25:16];
    if (!cmd[26]) return 32'h0;
    if (f == 10'h021) return (32'd1 << 27) + 32'd4 + 32'd8;
    if (f == 10'h041) return (32'd1 << 27) + (32'h0141_0E20 >> 16);
    if (f == 10'h061) return (32'd1 << 27) + (32'h0141_0E20 & 32'hFFFF);
    return 32'd1 << 27;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] cmd;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 rdata after release", bus_rdata, 32'h0);
    bus_read(OFF, rd);
    check("R1 first read", rd, 32'h0);

    // R4 R5 R6 named points
    bus_write(OFF, 32'h0421_0000); bus_read(OFF, rd);
    check("R4 status", rd, 32'h0800_000C);
    bus_write(OFF, 32'h0441_FFFF); bus_read(OFF, rd);
    check("R5 id upper", rd, 32'h0800_0141);
    bus_write(OFF, 32'hF461_1234); bus_read(OFF, rd);
    check("R6 id lower", rd, 32'h0800_0E20);

    // Sweep all fields with opcode set and clear, varying ignored bits (R2 R3 R7)
    for (int op = 0; op < 2; op++) begin
      for (int f = 0; f < 1024; f++) begin
        cmd = {4'((f * 7) & 15), 1'((f >> 2) & 1), 1'(op), 10'(f), 16'((f * 40503) & 16'hFFFF)};
        bus_write(OFF, cmd);
        bus_read(OFF, rd);
        if (op == 0) check("R3 opcode clear sweep", rd, expect_resp(cmd));
        else         check("R7 opcode set sweep", rd, expect_resp(cmd));
      end
    end

    // R2: same field, different data bits give the same answer
    bus_write(OFF, 32'h0441_0000); bus_read(OFF, rd);
    check("R2 data bits zero", rd, 32'h0800_0141);
    bus_write(OFF, 32'hFC41_FFFF); bus_read(OFF, rd);
    check("R2 data bits ones", rd, 32'h0800_0141);

    // R8: unmapped reads
    bus_write(OFF, 32'h0421_0000);
    for (int a = 0; a < 4096; a += 4) begin
      if (a != 16) begin
        bus_read(ADDR_W'(a), rd);
        check("R8 unmapped read", rd, 32'h0);
      end
    end
    // R8: unmapped writes do not touch the command
    for (int a = 0; a < 4096; a += 52) begin
      if (a != 16) begin
        bus_write(ADDR_W'(a), 32'h0000_0000);
        bus_write(ADDR_W'(a ^ 12'h800 ^ 16), 32'h0461_0000);
      end
    end
    bus_read(OFF, rd);
    check("R8 command kept after unmapped writes", rd, 32'h0800_000C);

    // R9: read same cycle as write sees old command
    @(negedge clk);
    bus_addr = OFF; bus_wdata = 32'h0441_0000; bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check("R9 read with write sees old", bus_rdata, 32'h0800_000C);
    bus_read(OFF, rd);
    check("R9 next read sees new", rd, 32'h0800_0141);

    // R9: hold between reads
    bus_addr = 12'h123;
    bus_write(OFF, 32'h0000_0000);
    repeat (3) @(negedge clk);
    check("R9 rdata held", bus_rdata, 32'h0800_0141);
    bus_read(OFF, rd);
    check("R9 held value replaced", rd, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule